// File: doc/BRIEF.md
# Bidirectional Connection Setup Sequencer

This block sits between a host processor and the connection memory of a time-slot switch. The host loads a command word and a source word. It then writes a destination word, and that write starts a write into the connection memory. The memory word places the source stream and slot at the address formed from the destination stream and slot. The command word chooses the main connection memory or the auxiliary one. For the auxiliary memory, on a multiplex configured for GCI framing, the address is built from the channel fields of the word: monitor or command/indicate, transmit or receive, the multiplex, and the channel number.

The status register holds a mode bit that the host can write. When the bit is set, one destination write produces two memory writes on consecutive cycles. The first is the forward path. The second is the mirrored path, in which source and destination swap roles and so do their stream fields. While the sequencer is writing, a read-only BUSY flag is high. A destination write that arrives in that window is dropped. Command, source and status writes in the same window are stored, but they do not disturb the operation already running, because everything it needs is captured at launch.

The `mux_gci` input is static configuration and should only change while BUSY is low. Host reads are combinational from `host_addr`.

Top module: `xconn_setup_ctl`

## Requirements
- R1: After reset, every register reads 0x00, the status register included, and `cm_we` is low.
- R2: Host register addresses are 0 command, 1 source, 2 destination and 3 status. A write to the command or the source register stores the value, which then reads back, and causes no memory write.
- R3: A destination write accepted while BUSY is low raises BUSY (status bit 6) from the next cycle. BUSY stays high for one cycle in single mode and for two cycles in bidirectional mode, then falls. A destination write in the first cycle after BUSY falls is accepted.
- R4: Command bits [1:0] hold the source stream, bits [3:2] the destination stream, and bit 7 selects the memory (1 main, 0 auxiliary; `cm_aux` is 1 for auxiliary). Source and destination bits [4:0] hold the slot. The forward write drives `cm_we` for exactly one cycle with `cm_addr` = {dest stream, dest slot} and `cm_data` = {source stream, source slot}.
- R5: When the mode bit (status bit 7) is 1, a second write follows in the very next cycle with `cm_addr` = {source stream, source slot} and `cm_data` = {dest stream, dest slot}.
- R6: Of the status bits, only bit 7 is writable. Status reads return {mode, BUSY, 6'b0}, and writes to bits 6..0 have no effect.
- R7: A destination write while BUSY is high is ignored. It produces no memory write, and the destination register keeps its earlier value.
- R8: Command, source and status writes while BUSY is high are stored, but the running operation keeps the words and the mode captured at launch.
- R9: When command bit 7 is 0 and `mux_gci` bit [word bit 3] is 1, the address is {1, bit 3 (multiplex), bit 5 (transmit), bit 6 (monitor), bits [2:0] (channel)} of the destination word. The mirrored write decodes the source word the same way.
- R10: When command bit 7 is 1, or when the multiplex named by word bit 3 is not GCI, the channel fields are ignored and the address is built as in R4 and R5. `cm_aux` still follows command bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| mux_gci | input | 2 | Per-multiplex GCI framing enable (static) |
| cm_we | output | 1 | Connection memory write enable |
| cm_aux | output | 1 | Auxiliary memory selected for this write |
| cm_addr | output | 7 | Connection memory address |
| cm_data | output | 7 | Connection memory write data |

## Verification
A host register write can land on the same clock edge at which the sequencer drives a connection-memory write. Such a write may be a second destination write, a command rewrite, or a clear of the mode bit. The bench provokes this by issuing those writes on the cycles directly after a destination write, while BUSY is high. A scoreboard compares each memory word with the one computed from the values present at launch. Register readbacks afterwards show that the command and mode writes took effect and that the late destination write left no trace.

// File: rtl/xconn_pkg.sv
package xconn_pkg;
  localparam int REG_W    = 8;
  localparam int CM_BIT   = 7;   // command: 1 = main memory, 0 = auxiliary
  localparam int BID_BIT  = 7;   // status: bidirectional mode
  localparam int BUSY_BIT = 6;   // status: write sequence running
  localparam int MON_BIT  = 6;   // word: monitor channel
  localparam int TX_BIT   = 5;   // word: transmit direction
  localparam int MUX_BIT  = 3;   // word: GCI multiplex select
  localparam int NEAR_W   = 7;   // word bits used when decoding an address

  typedef enum logic [1:0] {
    RA_CMD  = 2'd0,
    RA_SRC  = 2'd1,
    RA_DST  = 2'd2,
    RA_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_FWD  = 2'd1,
    SQ_MIR  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic             bid;
    logic [REG_W-1:0] cmd;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
  } conn_snap_t;
endpackage

// File: rtl/xconn_rst_sync.sv
module xconn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xconn_regs.sv
module xconn_regs
  import xconn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  input  logic             busy,
  output logic [REG_W-1:0] host_rdata,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] dst_q,
  output logic             bid_q,
  output logic             launch
);
  logic             wr_cmd, wr_src, wr_dst, wr_stat;
  logic [REG_W-1:0] cmd_d, src_d, dst_d;
  logic             bid_d;
  logic [REG_W-1:0] stat_word;

  // write decode and next values
  always_comb begin
    wr_cmd  = host_wr && (host_addr == RA_CMD);
    wr_src  = host_wr && (host_addr == RA_SRC);
    wr_dst  = host_wr && (host_addr == RA_DST);
    wr_stat = host_wr && (host_addr == RA_STAT);
    launch  = wr_dst && !busy;
    cmd_d   = wr_cmd  ? host_wdata : cmd_q;
    src_d   = wr_src  ? host_wdata : src_q;
    dst_d   = launch  ? host_wdata : dst_q;
    bid_d   = wr_stat ? host_wdata[BID_BIT] : bid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      bid_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      src_q <= src_d;
      dst_q <= dst_d;
      bid_q <= bid_d;
    end
  end

  // read path
  always_comb begin
    stat_word           = '0;
    stat_word[BID_BIT]  = bid_q;
    stat_word[BUSY_BIT] = busy;
    case (host_addr)
      RA_CMD:  host_rdata = cmd_q;
      RA_SRC:  host_rdata = src_q;
      RA_DST:  host_rdata = dst_q;
      default: host_rdata = stat_word;
    endcase
  end

  // R2: command register only changes on its own write
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == RA_CMD) |=> $stable(cmd_q));

  // R7: destination register frozen while a sequence runs
  p_dst_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dst_q));

  // R6: mode bit only changes on a status write
  p_bid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == RA_STAT) |=> $stable(bid_q));
endmodule

// File: rtl/xconn_seq.sv
module xconn_seq
  import xconn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             bid_in,
  input  logic [REG_W-1:0] cmd_in,
  input  logic [REG_W-1:0] src_in,
  input  logic [REG_W-1:0] dst_in,
  output logic             busy,
  output logic             we,
  output logic             mir_sel,
  output conn_snap_t       snap_q
);
  seq_st_e    st_q, st_d;
  conn_snap_t snap_d;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (launch) st_d = SQ_FWD;
      SQ_FWD:  st_d = snap_q.bid ? SQ_MIR : SQ_IDLE;
      SQ_MIR:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  // launch-time capture
  always_comb begin
    snap_d = snap_q;
    if (launch) begin
      snap_d.bid = bid_in;
      snap_d.cmd = cmd_in;
      snap_d.src = src_in;
      snap_d.dst = dst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      snap_q <= '0;
    end else begin
      st_q   <= st_d;
      snap_q <= snap_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign we      = (st_q == SQ_FWD) || (st_q == SQ_MIR);
  assign mir_sel = (st_q == SQ_MIR);

  // R3: accepted destination write starts a write next cycle
  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && we && !mir_sel));

  // R3: single mode finishes after one write
  p_single_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FWD && !snap_q.bid) |=> (st_q == SQ_IDLE));

  // R5: bidirectional mode writes the mirror right after the forward path
  p_mirror_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FWD && snap_q.bid) |=> (st_q == SQ_MIR));

  // R8: captured values hold while a sequence runs
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(snap_q));
endmodule

// File: rtl/xconn_path_fmt.sv
module xconn_path_fmt
  import xconn_pkg::*;
#(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 5,
  parameter int GCH_W  = 3
) (
  input  logic                     main_sel,
  input  logic [NEAR_W-1:0]        near_word,
  input  logic [STRM_W-1:0]        near_strm,
  input  logic [SLOT_W-1:0]        far_slot,
  input  logic [STRM_W-1:0]        far_strm,
  input  logic [1:0]               mux_gci,
  output logic [STRM_W+SLOT_W-1:0] addr,
  output logic [STRM_W+SLOT_W-1:0] data
);
  localparam int ADDR_W = STRM_W + SLOT_W;
  localparam int GCI_W  = GCH_W + 4;

  logic             gci_hit;
  logic [GCI_W-1:0] gci_addr;
  logic [ADDR_W-1:0] plain_addr;

  always_comb begin
    gci_hit    = !main_sel && mux_gci[near_word[MUX_BIT]];
    gci_addr   = {1'b1, near_word[MUX_BIT], near_word[TX_BIT],
                  near_word[MON_BIT], near_word[GCH_W-1:0]};
    plain_addr = {near_strm, near_word[SLOT_W-1:0]};
    addr       = gci_hit ? ADDR_W'(gci_addr) : plain_addr;
    data       = {far_strm, far_slot};
  end
endmodule

// File: rtl/xconn_map.sv
module xconn_map
  import xconn_pkg::*;
#(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 5,
  parameter int GCH_W  = 3
) (
  input  conn_snap_t               snap,
  input  logic [1:0]               mux_gci,
  input  logic                     we,
  input  logic                     mir_sel,
  output logic                     cm_aux,
  output logic [STRM_W+SLOT_W-1:0] cm_addr,
  output logic [STRM_W+SLOT_W-1:0] cm_data
);
  localparam int ADDR_W = STRM_W + SLOT_W;
  localparam int NPATH  = 2;

  logic [STRM_W-1:0] ss, ds;
  logic [ADDR_W-1:0] path_addr [NPATH];
  logic [ADDR_W-1:0] path_data [NPATH];
  logic              unused_bits;

  assign ss = snap.cmd[STRM_W-1:0];
  assign ds = snap.cmd[2*STRM_W-1:STRM_W];
  assign unused_bits = ^{snap.cmd[CM_BIT-1:2*STRM_W], snap.src[REG_W-1:NEAR_W],
                         snap.dst[REG_W-1:NEAR_W], snap.bid};

  // path 0 is forward, path 1 is mirrored (roles and streams swapped)
  for (genvar gi = 0; gi < NPATH; gi++) begin : g_path
    logic [NEAR_W-1:0] near_w;
    logic [STRM_W-1:0] near_s, far_s;
    logic [SLOT_W-1:0] far_sl;
    if (gi == 0) begin : g_fwd
      assign near_w = snap.dst[NEAR_W-1:0];
      assign near_s = ds;
      assign far_sl = snap.src[SLOT_W-1:0];
      assign far_s  = ss;
    end else begin : g_mir
      assign near_w = snap.src[NEAR_W-1:0];
      assign near_s = ss;
      assign far_sl = snap.dst[SLOT_W-1:0];
      assign far_s  = ds;
    end
    xconn_path_fmt #(.STRM_W(STRM_W), .SLOT_W(SLOT_W), .GCH_W(GCH_W)) u_fmt (
      .main_sel  (snap.cmd[CM_BIT]),
      .near_word (near_w),
      .near_strm (near_s),
      .far_slot  (far_sl),
      .far_strm  (far_s),
      .mux_gci   (mux_gci),
      .addr      (path_addr[gi]),
      .data      (path_data[gi])
    );
  end

  always_comb begin
    cm_aux  = we && !snap.cmd[CM_BIT];
    cm_addr = we ? path_addr[mir_sel] : '0;
    cm_data = we ? path_data[mir_sel] : '0;
  end
endmodule

// File: rtl/xconn_setup_ctl.sv
module xconn_setup_ctl
  import xconn_pkg::*;
#(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 5,
  parameter int GCH_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               host_addr,
  input  logic                     host_wr,
  input  logic [REG_W-1:0]         host_wdata,
  output logic [REG_W-1:0]         host_rdata,
  input  logic [1:0]               mux_gci,
  output logic                     cm_we,
  output logic                     cm_aux,
  output logic [STRM_W+SLOT_W-1:0] cm_addr,
  output logic [STRM_W+SLOT_W-1:0] cm_data
);
  logic             srst_n;
  logic             busy, launch, bid_q, mir_sel;
  logic [REG_W-1:0] cmd_q, src_q, dst_q;
  conn_snap_t       snap_q;

  xconn_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  xconn_regs u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .host_rdata (host_rdata),
    .cmd_q      (cmd_q),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .bid_q      (bid_q),
    .launch     (launch)
  );

  // destination is taken from the write data itself at launch
  xconn_seq u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .launch  (launch),
    .bid_in  (bid_q),
    .cmd_in  (cmd_q),
    .src_in  (src_q),
    .dst_in  (host_wdata),
    .busy    (busy),
    .we      (cm_we),
    .mir_sel (mir_sel),
    .snap_q  (snap_q)
  );

  xconn_map #(.STRM_W(STRM_W), .SLOT_W(SLOT_W), .GCH_W(GCH_W)) u_map (
    .snap    (snap_q),
    .mux_gci (mux_gci),
    .we      (cm_we),
    .mir_sel (mir_sel),
    .cm_aux  (cm_aux),
    .cm_addr (cm_addr),
    .cm_data (cm_data)
  );

  logic unused_dst;
  assign unused_dst = ^dst_q;

  // R5: in the main memory the second of two back-to-back writes swaps address and data
  p_mirror_swap_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (cm_we && $past(cm_we) && !cm_aux) |->
      (cm_addr == $past(cm_data) && cm_data == $past(cm_addr)));
endmodule

// File: tb/xconn_setup_ctl_tb.sv
module xconn_setup_ctl_tb;
  localparam int AW = 7;
  typedef logic [2*AW:0] item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    host_addr;
  logic          host_wr;
  logic [7:0]    host_wdata;
  logic [7:0]    host_rdata;
  logic [1:0]    mux_gci;
  logic          cm_we, cm_aux;
  logic [AW-1:0] cm_addr, cm_data;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  item_t exp_q[$];
  string tag_q[$];
  item_t mon_e;
  string mon_t;

  always #4 clk = ~clk;

  xconn_setup_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mux_gci(mux_gci),
    .cm_we(cm_we), .cm_aux(cm_aux), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // address model from R4, R9, R10
  function automatic logic [AW-1:0] mk_addr(logic aux, logic [7:0] w,
                                            logic [1:0] strm, logic [1:0] gci);
    if (aux && gci[w[3]]) return {1'b1, w[3], w[5], w[6], w[2:0]};
    return {strm, w[4:0]};
  endfunction

  // driver side of the scoreboard: expected memory words
  task automatic expect_conn(logic [7:0] cmd, logic [7:0] src, logic [7:0] dst,
                             logic bid, string tag);
    logic aux;
    aux = !cmd[7];
    exp_q.push_back({aux, mk_addr(aux, dst, cmd[3:2], mux_gci), cmd[1:0], src[4:0]});
    tag_q.push_back({tag, " forward"});
    if (bid) begin
      exp_q.push_back({aux, mk_addr(aux, src, cmd[1:0], mux_gci), cmd[3:2], dst[4:0]});
      tag_q.push_back({tag, " mirror"});
    end
  endtask

  // monitor side: every memory write must match the next expected word
  always @(negedge clk) begin
    if (rst_n && cm_we && !done) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R2/R7 unexpected write actual=%h expected=none",
                 {cm_aux, cm_addr, cm_data});
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, {1'b0, cm_aux, cm_addr, cm_data}, {1'b0, mon_e});
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(logic [1:0] a, logic [7:0] d);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic rdchk(logic [1:0] a, logic [7:0] exp, string tag);
    host_addr = a;
    host_wr   = 1'b0;
    #1;
    chk(tag, {8'h00, host_rdata}, {8'h00, exp});
    @(negedge clk);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; host_addr = 2'd0; host_wr = 1'b0; host_wdata = 8'h00; mux_gci = 2'b00;
    cycles(5);
    rst_n = 1'b1;
    cycles(4);

    // R1: reset values
    chk("R1 cm_we", {15'd0, cm_we}, 16'd0);
    rdchk(2'd3, 8'h00, "R1 status");
    rdchk(2'd0, 8'h00, "R1 command");
    rdchk(2'd2, 8'h00, "R1 destination");

    // R2: command and source only load
    wr(2'd0, 8'h89);
    wr(2'd1, 8'h05);
    cycles(2);
    rdchk(2'd0, 8'h89, "R2 command readback");
    rdchk(2'd1, 8'h05, "R2 source readback");

    // R3/R4: single write, BUSY for one cycle
    expect_conn(8'h89, 8'h05, 8'h13, 1'b0, "R4");
    wr(2'd2, 8'h13);
    rdchk(2'd3, 8'h40, "R3 busy set");
    rdchk(2'd3, 8'h00, "R3 busy clear single");

    // R6: only bit 7 of status is writable
    wr(2'd3, 8'hFF);
    rdchk(2'd3, 8'h80, "R6 status write mask");

    // R5: bidirectional pair, BUSY for two cycles
    wr(2'd0, 8'h8E);
    wr(2'd1, 8'h1F);
    expect_conn(8'h8E, 8'h1F, 8'h00, 1'b1, "R5");
    wr(2'd2, 8'h00);
    rdchk(2'd3, 8'hC0, "R5 busy forward");
    rdchk(2'd3, 8'hC0, "R5 busy mirror");
    rdchk(2'd3, 8'h80, "R5 busy clear");

    // R7: destination write during BUSY is dropped
    expect_conn(8'h8E, 8'h1F, 8'h07, 1'b1, "R7");
    wr(2'd2, 8'h07);
    wr(2'd2, 8'h11);
    cycles(3);
    rdchk(2'd2, 8'h07, "R7 destination unchanged");

    // R8: status and command writes during BUSY
    expect_conn(8'h8E, 8'h1F, 8'h0A, 1'b1, "R8");
    wr(2'd2, 8'h0A);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h81);
    cycles(3);
    rdchk(2'd0, 8'h81, "R8 command stored");
    rdchk(2'd3, 8'h00, "R8 mode stored");

    // R9: auxiliary memory on a GCI multiplex
    mux_gci = 2'b10;
    wr(2'd0, 8'h06);
    wr(2'd1, 8'h0A);
    expect_conn(8'h06, 8'h0A, 8'h4D, 1'b0, "R9 single");
    wr(2'd2, 8'h4D);
    cycles(3);
    wr(2'd3, 8'h80);
    wr(2'd1, 8'h2B);
    expect_conn(8'h06, 8'h2B, 8'h4D, 1'b1, "R9 bidir");
    wr(2'd2, 8'h4D);
    cycles(3);

    // R10: channel fields ignored without GCI or for main memory
    mux_gci = 2'b00;
    expect_conn(8'h06, 8'h2B, 8'h4D, 1'b1, "R10 no gci");
    wr(2'd2, 8'h4D);
    cycles(3);
    mux_gci = 2'b11;
    wr(2'd0, 8'h86);
    expect_conn(8'h86, 8'h2B, 8'h4D, 1'b1, "R10 main memory");
    wr(2'd2, 8'h4D);
    cycles(3);

    // R3: accepted right after BUSY falls
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h85);
    expect_conn(8'h85, 8'h2B, 8'h03, 1'b0, "R3 first");
    expect_conn(8'h85, 8'h2B, 8'h04, 1'b0, "R3 back to back");
    wr(2'd2, 8'h03);
    cycles(1);
    wr(2'd2, 8'h04);
    cycles(4);
    chk("R3 all expected writes seen", 16'(exp_q.size()), 16'd0);

    finish_run();
  end
endmodule